// File: doc/BRIEF.md
# Hot-Plug Slot Bring-Up Sequencer

This block controls one NVMe drive bay and takes it from empty to a trained, usable link in a fixed and checked order. It watches a raw, bouncing presence contact, a slot power-good flag, a reference-clock-valid flag and a link-up indication. It drives the active-low endpoint reset. It reports the slot state as a 3-bit code, together with an error flag that shows the last bring-up attempt failed.

The raw presence contact is synchronised and filtered. A change counts only after the new level has held for a set number of cycles, so each insertion or removal gives exactly one transition. After that the sequencer waits for slot power, then for the reference clock. It then holds reset low for a fixed window, releases it, and gives link training a bounded time to finish. A training timeout, a loss of power, clock or link after release, or a slot that has gone through a fault all lead to the fault state. From there the block holds reset for a full window before it tries again. The retry repeats every prerequisite check and a complete new hold window. Losing filtered presence in any state returns the slot to empty.

Power-good, clock-valid and link-up are taken to be synchronous to `clk_i`. Only the presence contact is asynchronous. All windows are parameters counted in clock cycles.

Top module: `hp_slot_seq`

## Requirements
- R1: While and after reset, the state code is EMPTY, `ep_rst_no` is 0 and `seq_err_o` is 0.
- R2: A change of the raw presence input that lasts fewer than `DEB_CYC` cycles is ignored. This holds both for insertion bounce seen from EMPTY, where the state never passes DEBOUNCE, and for a short drop while UP, where the state stays UP. A level held for `DEB_CYC` cycles, plus 2 synchroniser cycles, is accepted.
- R3: After presence is accepted the state is WAIT_PWR until power-good is high, then WAIT_CLK until the clock-valid flag is high. A power loss in WAIT_CLK returns the state to WAIT_PWR.
- R4: `ep_rst_no` rises only if power-good and clock-valid were both high in the cycle before the edge that released it. It stays 0 in all states other than TRAINING and UP.
- R5: Reset is released exactly `RST_HOLD_CYC` cycles after the first edge at which all prerequisites are met. If power or clock drops during the hold, the state goes back to WAIT_PWR or WAIT_CLK and the window restarts in full.
- R6: If power-good is low at an edge, `ep_rst_no` is 0 after that edge. In TRAINING or UP this moves the state to FAULT and sets `seq_err_o`.
- R7: If link-up is not seen within `TRAIN_CYC` cycles of TRAINING, the state becomes FAULT and `seq_err_o` is 1.
- R8: FAULT holds reset low for `RST_HOLD_CYC` cycles and then moves to WAIT_PWR. A retry therefore keeps reset low for exactly 2·`RST_HOLD_CYC`+2 cycles when power and clock are present.
- R9: When filtered presence is lost, the block moves from any later state to EMPTY, with reset low and `seq_err_o` cleared.
- R10: Link-up during TRAINING moves the state to UP at the next edge and clears `seq_err_o`. Loss of link-up or clock while UP moves the state to FAULT.
- R11: State codes: EMPTY=0, DEBOUNCE=1, WAIT_PWR=2, WAIT_CLK=3, RESET_HOLD=4, TRAINING=5, UP=6, FAULT=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| present_raw_i | input | 1 | Raw presence contact, high when a drive is seated, may bounce |
| pwr_good_i | input | 1 | Slot power good |
| refclk_ok_i | input | 1 | Reference clock valid |
| link_up_i | input | 1 | Link training complete |
| ep_rst_no | output | 1 | Endpoint reset, active low |
| slot_state_o | output | 3 | Slot state code (R11) |
| seq_err_o | output | 1 | Last bring-up attempt failed |

## Verification
The hardest case to reach from the ports is a window that restarts partway through. A reset hold is broken by a clock dropout, and the released reset must then still come exactly one full window after the prerequisites return. The bench reaches this with directed dropouts inside the hold. It also reaches a training timeout and a power loss in UP, and follows each into a counted retry. Randomly timed bursts of presence bounce, each shorter than the filter, check that the sequence never moves past DEBOUNCE. Random waits before power and clock then check that the release delay does not depend on how long the prerequisites took to arrive.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY      = 3'd0,
    ST_DEBOUNCE   = 3'd1,
    ST_WAIT_PWR   = 3'd2,
    ST_WAIT_CLK   = 3'd3,
    ST_RESET_HOLD = 3'd4,
    ST_TRAINING   = 3'd5,
    ST_UP         = 3'd6,
    ST_FAULT      = 3'd7
  } slot_st_e;
endpackage

// File: rtl/slot_pres_filter.sv
module slot_pres_filter #(
  parameter int DEB_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o,
  output logic flt_o
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      flt_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == flt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        flt_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sync_o = sync_q[1];
  assign flt_o  = flt_q;
endmodule

// File: rtl/slot_cycle_timer.sv
module slot_cycle_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_seq_pkg::*;
#(
  parameter int RST_HOLD_CYC = 1000,
  parameter int TRAIN_CYC    = 5000,
  parameter int CNT_W        = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pres_raw_i,
  input  logic             pres_flt_i,
  input  logic             pwr_good_i,
  input  logic             refclk_ok_i,
  input  logic             link_up_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  output logic             tmr_clr_o,
  output slot_st_e         state_o,
  output logic             ep_rst_no,
  output logic             seq_err_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(RST_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TRAIN_LAST = CNT_W'(TRAIN_CYC - 1);

  slot_st_e st_q, st_d;
  logic     rst_n_q, err_q, err_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_EMPTY:      if (pres_raw_i) st_d = ST_DEBOUNCE;
      ST_DEBOUNCE:   if (pres_flt_i) st_d = ST_WAIT_PWR;
                     else if (!pres_raw_i) st_d = ST_EMPTY;
      ST_WAIT_PWR:   if (pwr_good_i) st_d = ST_WAIT_CLK;
      ST_WAIT_CLK:   if (!pwr_good_i) st_d = ST_WAIT_PWR;
                     else if (refclk_ok_i) st_d = ST_RESET_HOLD;
      ST_RESET_HOLD: if (!pwr_good_i) st_d = ST_WAIT_PWR;
                     else if (!refclk_ok_i) st_d = ST_WAIT_CLK;
                     else if (tmr_cnt_i == HOLD_LAST) st_d = ST_TRAINING;
      ST_TRAINING:   if (!pwr_good_i || !refclk_ok_i) st_d = ST_FAULT;
                     else if (link_up_i) st_d = ST_UP;
                     else if (tmr_cnt_i == TRAIN_LAST) st_d = ST_FAULT;
      ST_UP:         if (!pwr_good_i || !refclk_ok_i || !link_up_i) st_d = ST_FAULT;
      ST_FAULT:      if (tmr_cnt_i == HOLD_LAST) st_d = ST_WAIT_PWR;
      default:       st_d = ST_EMPTY;
    endcase
    // filtered removal overrides everything past debounce
    if (!pres_flt_i && st_q != ST_EMPTY && st_q != ST_DEBOUNCE) st_d = ST_EMPTY;
  end

  always_comb begin
    err_d = err_q;
    if (st_d == ST_FAULT)                        err_d = 1'b1;
    else if (st_d == ST_UP || st_d == ST_EMPTY)  err_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_EMPTY;
      rst_n_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rst_n_q <= (st_d == ST_TRAINING) || (st_d == ST_UP);
      err_q   <= err_d;
    end
  end

  assign tmr_clr_o = (st_d != st_q);
  assign state_o   = st_q;
  assign ep_rst_no = rst_n_q;
  assign seq_err_o = err_q;
endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq
  import slot_seq_pkg::*;
#(
  parameter int DEB_CYC      = 64,
  parameter int RST_HOLD_CYC = 1000,
  parameter int TRAIN_CYC    = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       present_raw_i,
  input  logic       pwr_good_i,
  input  logic       refclk_ok_i,
  input  logic       link_up_i,
  output logic       ep_rst_no,
  output logic [2:0] slot_state_o,
  output logic       seq_err_o
);
  localparam int MAX_WIN = (RST_HOLD_CYC > TRAIN_CYC) ? RST_HOLD_CYC : TRAIN_CYC;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  logic             pres_sync, pres_flt, tmr_clr;
  logic [CNT_W-1:0] tmr_cnt;
  slot_st_e         state;

  slot_pres_filter #(.DEB_CYC(DEB_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (present_raw_i),
    .sync_o (pres_sync),
    .flt_o  (pres_flt)
  );

  slot_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (tmr_cnt)
  );

  slot_seq_fsm #(
    .RST_HOLD_CYC (RST_HOLD_CYC),
    .TRAIN_CYC    (TRAIN_CYC),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pres_raw_i  (pres_sync),
    .pres_flt_i  (pres_flt),
    .pwr_good_i  (pwr_good_i),
    .refclk_ok_i (refclk_ok_i),
    .link_up_i   (link_up_i),
    .tmr_cnt_i   (tmr_cnt),
    .tmr_clr_o   (tmr_clr),
    .state_o     (state),
    .ep_rst_no   (ep_rst_no),
    .seq_err_o   (seq_err_o)
  );

  assign slot_state_o = state;
endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int RST_HOLD_CYC = 1000,
  parameter int TRAIN_CYC    = 5000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       refclk_ok_i,
  input logic       link_up_i,
  input logic       ep_rst_no,
  input logic [2:0] slot_state_o,
  input logic       seq_err_o
);
  int unsigned hold_cnt, train_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt  <= 0;
      train_cnt <= 0;
    end else begin
      hold_cnt  <= (slot_state_o == 3'd4) ? ((hold_cnt < RST_HOLD_CYC + 1) ? hold_cnt + 1 : hold_cnt) : 0;
      train_cnt <= (slot_state_o == 3'd5) ? ((train_cnt < TRAIN_CYC + 1) ? train_cnt + 1 : train_cnt) : 0;
    end
  end

  AST_RELEASE_NEEDS_PREREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ep_rst_no) |-> $past(pwr_good_i) && $past(refclk_ok_i)) else $error("release prereq"); // R4
  AST_RST_ONLY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_rst_no |-> (slot_state_o == 3'd5 || slot_state_o == 3'd6)) else $error("rst state"); // R4
  AST_PWR_DROP_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !ep_rst_no) else $error("pwr drop"); // R6
  AST_HOLD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ep_rst_no) |-> ($past(slot_state_o) == 3'd4 && hold_cnt == RST_HOLD_CYC)) else $error("hold window"); // R5
  AST_TRAIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_state_o == 3'd5 |-> train_cnt < TRAIN_CYC) else $error("train bound"); // R7
  AST_FAULT_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_state_o == 3'd7 |-> seq_err_o && !ep_rst_no) else $error("fault flag"); // R8
  AST_EMPTY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_state_o == 3'd0 |-> !ep_rst_no && !seq_err_o) else $error("empty clean"); // R9
  AST_UP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_state_o == 3'd6 && $past(slot_state_o) != 3'd6) |-> ($past(slot_state_o) == 3'd5 && $past(link_up_i))) else $error("up entry"); // R10
endmodule

bind hp_slot_seq slot_seq_chk #(
  .RST_HOLD_CYC (RST_HOLD_CYC),
  .TRAIN_CYC    (TRAIN_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_good_i   (pwr_good_i),
  .refclk_ok_i  (refclk_ok_i),
  .link_up_i    (link_up_i),
  .ep_rst_no    (ep_rst_no),
  .slot_state_o (slot_state_o),
  .seq_err_o    (seq_err_o)
);

// File: tb/hp_slot_seq_tb_top.sv
module hp_slot_seq_tb_top;
  localparam int DEB  = 6;
  localparam int HOLD = 12;
  localparam int TRN  = 20;

  localparam int S_EMPTY = 0, S_DEB = 1, S_WPWR = 2, S_WCLK = 3,
                 S_HOLD = 4, S_TRAIN = 5, S_UP = 6, S_FAULT = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pres = 1'b0, pwr = 1'b0, rclk = 1'b0, link = 1'b0;
  logic ep_rst_n, err;
  logic [2:0] st;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hp_slot_seq #(.DEB_CYC(DEB), .RST_HOLD_CYC(HOLD), .TRAIN_CYC(TRN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .present_raw_i(pres), .pwr_good_i(pwr),
    .refclk_ok_i(rclk), .link_up_i(link), .ep_rst_no(ep_rst_n),
    .slot_state_o(st), .seq_err_o(err));

  function automatic int exp_release();  return HOLD + 1;     endfunction
  function automatic int exp_retry_low(); return 2 * HOLD + 2; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas_rise(output int n);
    n = 0;
    do begin tick(1); n++; end while (!ep_rst_n && n < 1000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, maxst, w;
    void'($urandom(32'd5150));
    tick(3);
    chk("R1 state", st, S_EMPTY); chk("R1 rst", ep_rst_n, 0); chk("R1 err", err, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 state after", st, S_EMPTY);

    // R2: random bounce bursts, each shorter than the filter
    pwr = 1'b1; rclk = 1'b1; maxst = 0;
    for (int b = 0; b < 12; b++) begin
      pres = 1'b1;
      for (int k = 0, l = $urandom_range(DEB - 1, 1); k < l; k++) begin
        tick(1); if (st > maxst) maxst = st;
      end
      pres = 1'b0;
      for (int k = 0, l = $urandom_range(4, 1); k < l; k++) begin
        tick(1); if (st > maxst) maxst = st;
      end
    end
    tick(4); if (st > maxst) maxst = st;
    chk("R2 bounce max state", maxst, S_DEB);
    chk("R2 bounce settles", st, S_EMPTY);

    // R3 ordering
    pwr = 1'b0; rclk = 1'b0;
    pres = 1'b1; tick(DEB + 6);
    chk("R3 wait pwr", st, S_WPWR); chk("R4 rst low", ep_rst_n, 0);
    pwr = 1'b1; tick(3);
    chk("R3 wait clk", st, S_WCLK); chk("R4 rst low clk", ep_rst_n, 0);
    pwr = 1'b0; tick(1);
    chk("R3 pwr loss in wait clk", st, S_WPWR);
    pwr = 1'b1; tick(2);

    // R5 restart on clock dropout
    rclk = 1'b1; tick(HOLD / 2);
    chk("R5 in hold", st, S_HOLD); chk("R5 rst held", ep_rst_n, 0);
    rclk = 1'b0; tick(2);
    chk("R5 back to wait clk", st, S_WCLK); chk("R5 rst low", ep_rst_n, 0);
    rclk = 1'b1; meas_rise(n);
    chk("R5 release delay", n, exp_release());
    chk("R11 training code", st, S_TRAIN);

    // R7 training timeout
    tick(TRN - 1);
    chk("R7 still training", st, S_TRAIN);
    tick(1);
    chk("R7 fault", st, S_FAULT); chk("R7 err", err, 1); chk("R7 rst", ep_rst_n, 0);

    // R8 retry window
    n = 0;
    while (!ep_rst_n && n < 1000) begin
      tick(1); n++;
      if (n == HOLD / 2) chk("R8 in fault", st, S_FAULT);
      if (n == HOLD)     chk("R8 to wait pwr", st, S_WPWR);
    end
    chk("R8 retry low cycles", n, exp_retry_low());

    // R10 link up
    link = 1'b1; tick(1);
    chk("R10 up", st, S_UP); chk("R10 err cleared", err, 0); chk("R10 rst high", ep_rst_n, 1);

    // R2 short removal glitch while up
    pres = 1'b0; tick(DEB - 2); pres = 1'b1; tick(DEB + 4);
    chk("R2 glitch ignored", st, S_UP); chk("R2 rst kept", ep_rst_n, 1);

    // R6 power drop
    pwr = 1'b0; tick(1);
    chk("R6 fault", st, S_FAULT); chk("R6 rst", ep_rst_n, 0); chk("R6 err", err, 1);
    tick(HOLD + 2);
    chk("R8 parks in wait pwr", st, S_WPWR); chk("R8 rst low", ep_rst_n, 0);
    pwr = 1'b1; tick(2 * HOLD + 10);
    chk("R10 up again", st, S_UP);
    link = 1'b0; tick(1);
    chk("R10 link loss", st, S_FAULT);
    link = 1'b1; tick(2 * HOLD + 10);
    chk("R10 recovered", st, S_UP);
    rclk = 1'b0; tick(1);
    chk("R10 clk loss", st, S_FAULT); chk("R10 clk loss err", err, 1);

    // R9 removal from fault
    pres = 1'b0; tick(DEB + 4);
    chk("R9 empty", st, S_EMPTY); chk("R9 err cleared", err, 0); chk("R9 rst", ep_rst_n, 0);

    // random prerequisite timing
    for (int it = 0; it < 5; it++) begin
      pwr = 1'b0; rclk = 1'b0; link = 1'b0; pres = 1'b1;
      tick(DEB + 6);
      w = $urandom_range(15, 1); tick(w);
      chk("R3 rand wait pwr", st, S_WPWR); chk("R4 rand rst", ep_rst_n, 0);
      pwr = 1'b1; tick(1);
      w = $urandom_range(15, 1); tick(w);
      chk("R3 rand wait clk", st, S_WCLK);
      rclk = 1'b1; meas_rise(n);
      chk("R5 rand release", n, exp_release());
      if ($urandom_range(1, 0) == 1) begin
        link = 1'b1; tick(1); chk("R10 rand up", st, S_UP);
      end
      pres = 1'b0; pwr = 1'b0; rclk = 1'b0;
      tick(DEB + 6);
      chk("R9 rand empty", st, S_EMPTY); chk("R9 rand err", err, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule